// File: doc/BRIEF.md
# Indexed-Register Watchdog Timer

This block is a watchdog timer that software reaches through one pair of byte-wide ports. A write to port offset 0 stores a register index. An access at offset 1 then reads or writes the register that the stored index names. A down-counter sits behind the ports. It advances only on cycles where a 32768 Hz tick enable is high. When it runs out, it raises one of two system events: a non-maskable interrupt pulse or a reset request.

Software programs a timeout split over three byte registers, picks the expiry action with a 4-bit code, and sets an enable bit. After that it must strobe a reload bit before the count runs out. A sticky fired flag records that an expiry happened. Only an explicit write of zero clears it, so software can tell after the event that the watchdog caused it. The readback path is registered: the data port shows a value one clock after the index and the offset are presented.

Top module: `idx_wdog`

## Requirements
- R1: A write at offset 0 (`hst_addr`=0) stores `hst_wdata` as the index. While `hst_addr`=0, `hst_rdata` shows the stored index one clock later.
- R2: With `hst_addr`=1, `hst_rdata` shows the indexed register one clock later, according to this map:
  - 0x37 reads the enable in bit 6, with all other bits 0.
  - 0x38 reads the action code in bits 7:4, with bits 3:0 reading 0.
  - 0x39, 0x3A and 0x3B read timeout bits 7:0, 15:8 and 23:16.
  - 0x3C reads the fired flag in bit 7, with all other bits 0.
  - Any other index reads 0x00, even after it has been written.
- R3: The counter loads the timeout on the clock after the enable bit turns from 0 to 1. While the enable is 0, the counter holds its value and no expiry can occur, whatever ticks arrive.
- R4: With the enable set and timeout value N loaded, the expiry happens on the (N+1)-th tick. Cycles without `tick_en` do not count.
- R5: Writing 0x3C with bit 6 set reloads the counter from the timeout at once. Bit 6 always reads back 0.
- R6: An expiry sets the fired flag. Writing 0x3C with bit 7 = 0 clears the flag, and writing it with bit 7 = 1 leaves the flag unchanged. An expiry in the same cycle as a clear wins. The flag survives disable and reload.
- R7: On expiry, action code 0xC produces a one-cycle `nmi_o` pulse and code 0xD a one-cycle `rst_req_o` pulse. Any other code produces no pulse. The pulse appears on the clock after the expiring tick.
- R8: An expiry reloads the counter, so while enabled with no reloads, expiries repeat every N+1 ticks.
- R9: A synchronous active-high `rst` clears the index, the enable, the code, the timeout, the counter, the fired flag and all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32768 Hz count enable, one clock wide |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 1 | Port offset: 0 = index, 1 = data |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Registered read data |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The hardest case to reach from the ports is a counter that holds a partly used value across a disable, followed by an enable edge that must replace it. The bench drives ticks one at a time, stops part way through a period, disables the timer, and reprograms a shorter timeout while the timer is off. It then re-enables and counts ticks up to the pulse, so a missing load on the enable edge shows up as a late pulse. A reload strobe issued mid-period is checked the same way: from a stale counter the pulse would come earlier than N+1 ticks after the strobe.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] IDX_CTRL = 8'h37;
  localparam logic [7:0] IDX_SEL  = 8'h38;
  localparam logic [7:0] IDX_TO0  = 8'h39;
  localparam logic [7:0] IDX_CMD  = 8'h3C;
  localparam int EN_BIT     = 6;
  localparam int RELOAD_BIT = 6;
  localparam int FIRED_BIT  = 7;
  localparam logic [3:0] CODE_NMI = 4'hC;
  localparam logic [3:0] CODE_RST = 4'hD;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_NMI  = 2'd1,
    ACT_RST  = 2'd2
  } act_e;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  input  logic             expire,
  output logic             en,
  output logic [3:0]       sel,
  output logic [CNT_W-1:0] timeout,
  output logic             reload,
  output logic [DW-1:0]    rdata
);
  localparam int NB = (CNT_W + DW - 1) / DW;

  logic [DW-1:0]    idx_q;
  logic             en_q;
  logic [3:0]       sel_q;
  logic             fired_q;
  logic [DW-1:0]    rd_mux;
  logic [DW-1:0]    rdata_q;
  logic [NB*DW-1:0] to_flat;
  logic             data_wr;
  logic             hit_cmd;

  assign data_wr = wr && addr;
  assign hit_cmd = data_wr && (idx_q == IDX_CMD);

  // one byte register per timeout slice
  for (genvar k = 0; k < NB; k++) begin : g_to
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst) byte_q <= '0;
      else if (data_wr && idx_q == DW'(IDX_TO0 + k)) byte_q <= wdata;
    end
    assign to_flat[k*DW +: DW] = byte_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      en_q    <= 1'b0;
      sel_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (wr && !addr) idx_q <= wdata;
      if (data_wr && idx_q == IDX_CTRL) en_q <= wdata[EN_BIT];
      if (data_wr && idx_q == IDX_SEL) sel_q <= wdata[DW-1 -: 4];
      if (expire) fired_q <= 1'b1;
      else if (hit_cmd && !wdata[FIRED_BIT]) fired_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (!addr) begin
      rd_mux = idx_q;
    end else begin
      if (idx_q == IDX_CTRL) rd_mux[EN_BIT] = en_q;
      if (idx_q == IDX_SEL) rd_mux[DW-1 -: 4] = sel_q;
      if (idx_q == IDX_CMD) rd_mux[FIRED_BIT] = fired_q;
      for (int k = 0; k < NB; k++)
        if (idx_q == DW'(IDX_TO0 + k)) rd_mux = to_flat[k*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign en      = en_q;
  assign sel     = sel_q;
  assign timeout = to_flat[CNT_W-1:0];
  assign reload  = hit_cmd && wdata[RELOAD_BIT];
  assign rdata   = rdata_q;

  // R1: offset-0 write stores the index
  p_idx_store_r1: assert property (@(posedge clk) disable iff (rst)
    (wr && !addr) |=> (idx_q == $past(wdata)));
  // R6: expiry always leaves the flag set
  p_fired_set_r6: assert property (@(posedge clk) disable iff (rst)
    expire |=> fired_q);
  // R6: flag only drops after a zero write to bit 7
  p_fired_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (fired_q && !hit_cmd) |=> fired_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] timeout,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             en_d;
  logic             rise;
  logic             at_zero;

  assign rise    = en && !en_d;
  assign at_zero = (cnt_q == '0);
  assign expire  = en && en_d && tick && !reload && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_d  <= 1'b0;
    end else begin
      en_d <= en;
      if (rise || reload)  cnt_q <= timeout;
      else if (en && tick) cnt_q <= at_zero ? timeout : cnt_q - 1'b1;
    end
  end

  // R3: disabled counter holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!en && !reload) |=> $stable(cnt_q));
  // R4: a tick on a non-zero count steps down by one
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (en && en_d && tick && !reload && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R5: reload strobe copies the timeout
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt_q == $past(timeout)));
  // R8: expiry restarts the count from the timeout
  p_rearm_r8: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_q == $past(timeout)));
endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       expire,
  input  logic [3:0] sel,
  output logic       nmi,
  output logic       rst_req
);
  act_e act;
  logic nmi_q;
  logic rst_q;

  always_comb begin
    case (sel)
      CODE_NMI: act = ACT_NMI;
      CODE_RST: act = ACT_RST;
      default:  act = ACT_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      nmi_q <= expire && (act == ACT_NMI);
      rst_q <= expire && (act == ACT_RST);
    end
  end

  assign nmi     = nmi_q;
  assign rst_req = rst_q;

  // R7: at most one event at a time
  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({nmi_q, rst_q}));
  // R7: an event pulse follows an expiry cycle
  p_cause_r7: assert property (@(posedge clk) disable iff (rst)
    (nmi_q || rst_q) |-> $past(expire));
  // R7: interrupt pulse needs the interrupt code
  p_nmi_code_r7: assert property (@(posedge clk) disable iff (rst)
    nmi_q |-> ($past(sel) == CODE_NMI));
endmodule

// File: rtl/idx_wdog.sv
module idx_wdog #(
  parameter int CNT_W = 24,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          hst_wr,
  input  logic          hst_addr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          nmi_o,
  output logic          rst_req_o
);
  logic             en;
  logic [3:0]       sel;
  logic [CNT_W-1:0] timeout;
  logic             reload;
  logic             expire;

  wdt_regfile #(.CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr(hst_wr), .addr(hst_addr), .wdata(hst_wdata),
    .expire(expire), .en(en), .sel(sel), .timeout(timeout),
    .reload(reload), .rdata(hst_rdata)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick_en), .reload(reload),
    .timeout(timeout), .expire(expire)
  );

  wdt_action u_act (
    .clk(clk), .rst(rst), .expire(expire), .sel(sel),
    .nmi(nmi_o), .rst_req(rst_req_o)
  );
endmodule

// File: tb/sim_idx_wdog.sv
module sim_idx_wdog;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       hst_wr = 1'b0;
  logic       hst_addr = 1'b0;
  logic [7:0] hst_wdata = 8'h00;
  logic [7:0] hst_rdata;
  logic       nmi_o;
  logic       rst_req_o;

  int    nchk = 0;
  int    nfail = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R9";

  always #10 clk = ~clk;

  idx_wdog u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .hst_wr(hst_wr),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  // behavioural reference state
  logic [7:0] m_idx;
  bit         m_en, m_en_prev, m_fired, m_nmi, m_rst;
  int         m_sel, m_to, m_cnt, m_rd;
  bit         t_rise, t_rel, t_exp;
  int         t_rd, t_cnt;

  function automatic int reg_view(logic [7:0] i);
    case (i)
      8'h37:   return m_en ? 8'h40 : 0;
      8'h38:   return m_sel << 4;
      8'h39:   return m_to & 255;
      8'h3A:   return (m_to >> 8) & 255;
      8'h3B:   return (m_to >> 16) & 255;
      8'h3C:   return m_fired ? 8'h80 : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_idx = 0; m_en = 0; m_en_prev = 0; m_fired = 0; m_nmi = 0; m_rst = 0;
      m_sel = 0; m_to = 0; m_cnt = 0; m_rd = 0;
    end else begin
      t_rd   = hst_addr ? reg_view(m_idx) : int'(m_idx);
      t_rise = m_en && !m_en_prev;
      t_rel  = hst_wr && hst_addr && m_idx == 8'h3C && hst_wdata[6];
      t_exp  = m_en && !t_rise && !t_rel && tick_en && m_cnt == 0;
      t_cnt  = m_cnt;
      if (t_rise || t_rel) t_cnt = m_to;
      else if (m_en && tick_en) t_cnt = (m_cnt == 0) ? m_to : m_cnt - 1;
      m_en_prev = m_en;
      if (t_exp) m_fired = 1;
      else if (hst_wr && hst_addr && m_idx == 8'h3C && !hst_wdata[7]) m_fired = 0;
      m_nmi = t_exp && m_sel == 12;
      m_rst = t_exp && m_sel == 13;
      if (hst_wr && !hst_addr) m_idx = hst_wdata;
      else if (hst_wr) begin
        case (m_idx)
          8'h37: m_en = hst_wdata[6];
          8'h38: m_sel = int'(hst_wdata[7:4]);
          8'h39: m_to = (m_to & 32'hFFFF00) | int'(hst_wdata);
          8'h3A: m_to = (m_to & 32'hFF00FF) | (int'(hst_wdata) << 8);
          8'h3B: m_to = (m_to & 32'h00FFFF) | (int'(hst_wdata) << 16);
          default: ;
        endcase
      end
      m_cnt = t_cnt;
      m_rd  = t_rd;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cur_req, "model rdata", int'(hst_rdata), m_rd);
      chk(cur_req, "model nmi", int'(nmi_o), int'(m_nmi));
      chk(cur_req, "model rst_req", int'(rst_req_o), int'(m_rst));
    end
  end

  task automatic idle();
    hst_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(bit a, logic [7:0] d);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d; tick_en = 1'b0;
    @(negedge clk);
    idle();
  endtask

  task automatic wreg(logic [7:0] i, logic [7:0] d);
    wr(1'b0, i);
    wr(1'b1, d);
  endtask

  task automatic rd(logic [7:0] i, output int v);
    wr(1'b0, i);
    hst_addr = 1'b1;
    @(negedge clk);
    v = int'(hst_rdata);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick1();
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    int v;
    @(negedge clk); @(negedge clk); @(negedge clk);
    cmp_on = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    cur_req = "R9";
    chk("R9", "nmi after reset", int'(nmi_o), 0);
    chk("R9", "rst_req after reset", int'(rst_req_o), 0);
    chk("R9", "rdata after reset", int'(hst_rdata), 0);
    rd(8'h37, v); chk("R9", "ctrl after reset", v, 0);
    rd(8'h3C, v); chk("R9", "fired after reset", v, 0);

    // R1: index port readback
    cur_req = "R1";
    wr(1'b0, 8'h5A); hst_addr = 1'b0; step();
    chk("R1", "index readback", int'(hst_rdata), 8'h5A);

    // R2: map and unmapped index
    cur_req = "R2";
    wreg(8'h3B, 8'h12); rd(8'h3B, v); chk("R2", "timeout hi", v, 8'h12);
    wreg(8'h3B, 8'h00);
    wreg(8'h3A, 8'h00);
    wreg(8'h39, 8'h05); rd(8'h39, v); chk("R2", "timeout lo", v, 8'h05);
    wreg(8'h40, 8'hFF); rd(8'h40, v); chk("R2", "unmapped", v, 0);
    wreg(8'h38, 8'hC5); rd(8'h38, v); chk("R2", "select", v, 8'hC0);
    wreg(8'h37, 8'hFF); rd(8'h37, v); chk("R2", "ctrl", v, 8'h40);

    // R4 and R7: N=5 expires on tick 6 with an interrupt pulse
    cur_req = "R4";
    step();
    for (int i = 1; i <= 5; i++) begin
      tick1(); chk("R4", "no early nmi", int'(nmi_o), 0);
    end
    tick1();
    chk("R4", "nmi on tick N+1", int'(nmi_o), 1);
    chk("R7", "no reset with nmi code", int'(rst_req_o), 0);
    step();
    chk("R7", "nmi one cycle", int'(nmi_o), 0);
    rd(8'h3C, v); chk("R6", "fired set", v, 8'h80);

    // R8: repeat period
    cur_req = "R8";
    for (int i = 1; i <= 5; i++) begin
      tick1(); chk("R8", "no nmi mid period", int'(nmi_o), 0);
    end
    tick1(); chk("R8", "periodic nmi", int'(nmi_o), 1);

    // R6: write 1 keeps, write 0 clears
    cur_req = "R6";
    wreg(8'h3C, 8'h80); rd(8'h3C, v); chk("R6", "write one keeps", v, 8'h80);
    wreg(8'h3C, 8'h00); rd(8'h3C, v); chk("R6", "write zero clears", v, 0);

    // R7: reset code and unused code
    cur_req = "R7";
    wreg(8'h38, 8'hD0);
    for (int i = 1; i <= 5; i++) tick1();
    tick1();
    chk("R7", "reset pulse", int'(rst_req_o), 1);
    chk("R7", "no nmi with reset code", int'(nmi_o), 0);
    step(); chk("R7", "reset one cycle", int'(rst_req_o), 0);
    wreg(8'h38, 8'h50);
    for (int i = 1; i <= 6; i++) begin
      tick1();
      chk("R7", "unused code nmi", int'(nmi_o), 0);
      chk("R7", "unused code rst", int'(rst_req_o), 0);
    end
    rd(8'h3C, v); chk("R6", "fired with unused code", v, 8'h80);

    // R5: mid-period reload
    cur_req = "R5";
    wreg(8'h38, 8'hC0);
    for (int i = 1; i <= 3; i++) tick1();
    wreg(8'h3C, 8'h40);
    for (int i = 1; i <= 5; i++) begin
      tick1(); chk("R5", "no nmi after reload", int'(nmi_o), 0);
    end
    tick1(); chk("R5", "nmi N+1 after reload", int'(nmi_o), 1);
    rd(8'h3C, v); chk("R5", "reload bit reads 0", v, 8'h80);

    // R3: disable holds, enable edge loads
    cur_req = "R3";
    tick1(); tick1();
    wreg(8'h37, 8'h00);
    wreg(8'h39, 8'h02);
    rd(8'h3C, v); chk("R6", "fired kept over disable", v, 8'h80);
    for (int i = 1; i <= 20; i++) begin
      tick1(); chk("R3", "no nmi while disabled", int'(nmi_o), 0);
    end
    wreg(8'h37, 8'h40);
    step();
    for (int i = 1; i <= 2; i++) begin
      tick1(); chk("R3", "no early nmi after enable", int'(nmi_o), 0);
    end
    tick1(); chk("R3", "nmi from loaded value", int'(nmi_o), 1);
    step(); step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL %s watchdog expired actual 0 expected 1", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule